// File: doc/BRIEF.md
# Infrared Frame Transmit Start Controller

This block sits between the software-visible transmit controls of an infrared serial transmitter and its serializer. It decides the clock cycle in which a queued message may begin to go out on the line. A start needs several things together: transmit mode switched on, an accepted transmit command, an expired launch delay, enough data in the FIFO, an idle interaction-pulse generator, and no frame already in flight. When a start occurs, the block issues a one-cycle start strobe and drives an active-low frame-in-flight signal. When the serializer reports that the end-of-frame sequence has gone out, the block releases that signal and raises an end-of-message status flag and a pending interrupt.

The block supports two ways of issuing commands. In window mode, a single command covers a whole window of back-to-back frames, and the launch delay runs only before the first of them. In per-frame mode, each frame needs its own command, and each command restarts the delay. The data test also depends on the programmed FIFO threshold. A threshold of zero needs only a non-empty FIFO. A nonzero threshold needs the fill level to go above it, or the transmit-complete flag to be set.

Top module: `irtxLaunch`

## Requirements
- R1: `startPulse` rises only if, in the cycle before, all of these held: `txModeEn` high, a command accepted and not yet consumed, the delay counter at zero, `pulseBusy` low, and `frameActiveN` high. A `txCmd` that arrives while `txModeEn` is low is dropped.
- R2: When `thresholdCfg` is 0, the data condition is `fifoEmpty` low. `fifoLevel` is ignored.
- R3: When `thresholdCfg` is nonzero, the data condition is `fifoLevel` strictly greater than `thresholdCfg`, or `txComplete` high. `fifoEmpty` is ignored.
- R4: An accepted command that needs a delay loads `delayCfg` and restarts the tick prescaler. The count drops by one every `TICK_DIV` clock cycles, and a value of 0 counts as expired at once. If the other conditions already hold, `startPulse` appears in the cycle `delayCfg*TICK_DIV+1` clock edges after the edge that samples `txCmd`.
- R5: With `brickMode` high, a start opens a window. The command stays armed, so later frames start without a new command. A command that arrives while the window is open does not reload the delay.
- R6: With `brickMode` low, each start consumes the command, and each new command reloads the delay from `delayCfg`.
- R7: `startPulse` lasts exactly one cycle. In that same cycle `frameActiveN` is low and `eomFlag` is cleared.
- R8: `frameDone` sampled while `frameActiveN` is low sets `frameActiveN` high, `eomFlag` high and `eomIrq` high one edge later. `frameDone` is ignored while no frame is active.
- R9: `eomIrq` stays set until an `eomAck` is sampled. If `eomAck` and a completing `frameDone` are sampled at the same edge, `eomIrq` stays set.
- R10: Two events withdraw a pending command and close the window: `txModeEn` going low, or `brickMode` going low while a window is open. The next command then runs the delay again.
- R11: During reset, `startPulse`, `eomFlag` and `eomIrq` are 0 and `frameActiveN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txModeEn | input | 1 | Transmit mode enable |
| brickMode | input | 1 | Window mode: one command covers many frames |
| txCmd | input | 1 | Transmit command strobe |
| delayCfg | input | DELAY_W | Launch delay in ticks |
| thresholdCfg | input | LEVEL_W | FIFO threshold, 0 selects the non-empty test |
| fifoLevel | input | LEVEL_W | FIFO fill level |
| fifoEmpty | input | 1 | FIFO empty flag |
| txComplete | input | 1 | Transmit-complete flag, last byte queued |
| pulseBusy | input | 1 | Interaction-pulse generator active |
| frameDone | input | 1 | End-of-frame sequence sent by the serializer |
| eomAck | input | 1 | Write-one-to-clear for the interrupt |
| startPulse | output | 1 | One-cycle start strobe to the serializer |
| frameActiveN | output | 1 | Active-low frame in flight |
| eomFlag | output | 1 | End-of-message status |
| eomIrq | output | 1 | Pending end-of-message interrupt |

## Verification
The interrupt register can see a set event and a clear event at the same edge. This happens when the frame that completes and the software acknowledge of the previous interrupt are sampled together. The bench drives `frameDone` and `eomAck` in the same cycle and checks that `eomIrq` is still high afterwards. It then checks that a lone acknowledge clears it. The other overlap is in window mode: a frame ends, and the next start fires one cycle later with no command. The bench times that gap and compares every output, on every cycle, against a behavioural model.

// File: rtl/irtxLaunchPkg.sv
package irtxLaunchPkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadDelay;   // reload delay counter and restart the tick prescaler
  } launchStrobe_t;

  // Conditions from the datapath to the control
  typedef struct packed {
    logic delayDone;   // delay counter at zero
    logic dataReady;   // FIFO content satisfies the threshold rule
  } pathStatus_t;

endpackage

// File: rtl/irtxLaunchPath.sv
module irtxLaunchPath
  import irtxLaunchPkg::*;
#(
  parameter int DELAY_W  = 8,
  parameter int LEVEL_W  = 6,
  parameter int TICK_DIV = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  launchStrobe_t       strobe,
  input  logic [DELAY_W-1:0]  delayCfg,
  input  logic [LEVEL_W-1:0]  thresholdCfg,
  input  logic [LEVEL_W-1:0]  fifoLevel,
  input  logic                fifoEmpty,
  input  logic                txComplete,
  output pathStatus_t         status
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic               tick;
  logic [DELAY_W-1:0] delayCnt;

  generate
    if (TICK_DIV > 1) begin : g_prescale
      logic [PRE_W-1:0] preCnt;
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          preCnt <= '0;
        end else if (strobe.loadDelay || preCnt == PRE_LAST) begin
          preCnt <= '0;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end

      assign tick = (preCnt == PRE_LAST);
    end else begin : g_everyCycle
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      delayCnt <= '0;
    end else if (strobe.loadDelay) begin
      delayCnt <= delayCfg;
    end else if (tick && delayCnt != '0) begin
      delayCnt <= delayCnt - 1'b1;
    end
  end

  logic thrZero;
  logic levelAbove;

  always_comb begin
    thrZero    = (thresholdCfg == '0);
    levelAbove = (fifoLevel > thresholdCfg);
    status.delayDone = (delayCnt == '0);
    status.dataReady = thrZero ? !fifoEmpty : (levelAbove || txComplete);
  end

endmodule

// File: rtl/irtxLaunchCtrl.sv
module irtxLaunchCtrl
  import irtxLaunchPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          txModeEn,
  input  logic          brickMode,
  input  logic          txCmd,
  input  logic          pulseBusy,
  input  logic          frameDone,
  input  logic          eomAck,
  input  pathStatus_t   status,
  output launchStrobe_t strobe,
  output logic          startPulse,
  output logic          frameActiveN,
  output logic          eomFlag,
  output logic          eomIrq
);

  logic armed;
  logic sending;
  logic windowOpen;
  logic startQ;
  logic eomFlagQ;
  logic irqQ;

  logic cmdAccept;
  logic needDelay;
  logic startCond;
  logic doneEvt;
  logic windowEnd;

  always_comb begin
    cmdAccept = txCmd && txModeEn;
    needDelay = !(brickMode && windowOpen);
    doneEvt   = sending && frameDone;
    windowEnd = windowOpen && !brickMode;
    startCond = armed && txModeEn && status.delayDone && status.dataReady
                && !pulseBusy && !sending;
    strobe.loadDelay = cmdAccept && needDelay;
  end

  // Command arming and window tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed      <= 1'b0;
      windowOpen <= 1'b0;
    end else begin
      if (!txModeEn) begin
        armed <= 1'b0;
      end else if (cmdAccept) begin
        armed <= 1'b1;
      end else if ((startCond && !brickMode) || windowEnd) begin
        armed <= 1'b0;
      end

      if (!brickMode || !txModeEn) begin
        windowOpen <= 1'b0;
      end else if (startCond) begin
        windowOpen <= 1'b1;
      end
    end
  end

  // Frame launch, completion and status
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ   <= 1'b0;
      sending  <= 1'b0;
      eomFlagQ <= 1'b0;
      irqQ     <= 1'b0;
    end else begin
      startQ <= startCond;

      if (startCond) begin
        sending  <= 1'b1;
        eomFlagQ <= 1'b0;
      end else if (doneEvt) begin
        sending  <= 1'b0;
        eomFlagQ <= 1'b1;
      end

      if (doneEvt) begin
        irqQ <= 1'b1;
      end else if (eomAck) begin
        irqQ <= 1'b0;
      end
    end
  end

  assign startPulse   = startQ;
  assign frameActiveN = !sending;
  assign eomFlag      = eomFlagQ;
  assign eomIrq       = irqQ;

endmodule

// File: rtl/irtxLaunch.sv
module irtxLaunch
  import irtxLaunchPkg::*;
#(
  parameter int DELAY_W  = 8,
  parameter int LEVEL_W  = 6,
  parameter int TICK_DIV = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txModeEn,
  input  logic               brickMode,
  input  logic               txCmd,
  input  logic [DELAY_W-1:0] delayCfg,
  input  logic [LEVEL_W-1:0] thresholdCfg,
  input  logic [LEVEL_W-1:0] fifoLevel,
  input  logic               fifoEmpty,
  input  logic               txComplete,
  input  logic               pulseBusy,
  input  logic               frameDone,
  input  logic               eomAck,
  output logic               startPulse,
  output logic               frameActiveN,
  output logic               eomFlag,
  output logic               eomIrq
);

  launchStrobe_t strobe;
  pathStatus_t   status;

  irtxLaunchPath #(
    .DELAY_W (DELAY_W),
    .LEVEL_W (LEVEL_W),
    .TICK_DIV(TICK_DIV)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .delayCfg    (delayCfg),
    .thresholdCfg(thresholdCfg),
    .fifoLevel   (fifoLevel),
    .fifoEmpty   (fifoEmpty),
    .txComplete  (txComplete),
    .status      (status)
  );

  irtxLaunchCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .txModeEn    (txModeEn),
    .brickMode   (brickMode),
    .txCmd       (txCmd),
    .pulseBusy   (pulseBusy),
    .frameDone   (frameDone),
    .eomAck      (eomAck),
    .status      (status),
    .strobe      (strobe),
    .startPulse  (startPulse),
    .frameActiveN(frameActiveN),
    .eomFlag     (eomFlag),
    .eomIrq      (eomIrq)
  );

endmodule

// File: rtl/irtxLaunchChk.sv
module irtxLaunchChk #(
  parameter int LEVEL_W = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               txModeEn,
  input logic               pulseBusy,
  input logic [LEVEL_W-1:0] thresholdCfg,
  input logic [LEVEL_W-1:0] fifoLevel,
  input logic               fifoEmpty,
  input logic               txComplete,
  input logic               frameDone,
  input logic               eomAck,
  input logic               startPulse,
  input logic               frameActiveN,
  input logic               eomFlag,
  input logic               eomIrq
);

  a_r1_start_gated: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(frameActiveN && txModeEn && !pulseBusy));

  a_r2_empty_blocks: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(thresholdCfg != '0 || !fifoEmpty));

  a_r3_level_rule: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(thresholdCfg == '0 || fifoLevel > thresholdCfg || txComplete));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);

  a_r7_start_status: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> (!frameActiveN && !eomFlag));

  a_r8_done_raises: assert property (@(posedge clk) disable iff (!rstN)
    (!frameActiveN && frameDone) |=> (frameActiveN && eomFlag && eomIrq));

  a_r9_irq_held: assert property (@(posedge clk) disable iff (!rstN)
    (eomIrq && !eomAck) |=> eomIrq);

endmodule

bind irtxLaunch irtxLaunchChk #(.LEVEL_W(LEVEL_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .txModeEn    (txModeEn),
  .pulseBusy   (pulseBusy),
  .thresholdCfg(thresholdCfg),
  .fifoLevel   (fifoLevel),
  .fifoEmpty   (fifoEmpty),
  .txComplete  (txComplete),
  .frameDone   (frameDone),
  .eomAck      (eomAck),
  .startPulse  (startPulse),
  .frameActiveN(frameActiveN),
  .eomFlag     (eomFlag),
  .eomIrq      (eomIrq)
);

// File: tb/tb_irtxLaunch.sv
`timescale 1ns/1ps
module tb_irtxLaunch;

  localparam int DW  = 8;
  localparam int LW  = 6;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txModeEn = 1'b0, brickMode = 1'b0, txCmd = 1'b0;
  logic [DW-1:0] delayCfg = '0;
  logic [LW-1:0] thresholdCfg = '0, fifoLevel = '0;
  logic fifoEmpty = 1'b1, txComplete = 1'b0, pulseBusy = 1'b0;
  logic frameDone = 1'b0, eomAck = 1'b0;
  logic startPulse, frameActiveN, eomFlag, eomIrq;

  int checks = 0;
  int errors = 0;
  bit cmpOn = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irtxLaunch #(.DELAY_W(DW), .LEVEL_W(LW), .TICK_DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .txModeEn(txModeEn), .brickMode(brickMode),
    .txCmd(txCmd), .delayCfg(delayCfg), .thresholdCfg(thresholdCfg),
    .fifoLevel(fifoLevel), .fifoEmpty(fifoEmpty), .txComplete(txComplete),
    .pulseBusy(pulseBusy), .frameDone(frameDone), .eomAck(eomAck),
    .startPulse(startPulse), .frameActiveN(frameActiveN),
    .eomFlag(eomFlag), .eomIrq(eomIrq)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model, updated on every rising edge
  int  mCnt, mPre;
  bit  mArmed, mWin, mActive, mStart, mEom, mIrq;
  bit  tk, cmdOk, needDly, dataOk, go, done;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mPre = 0; mArmed = 0; mWin = 0;
      mActive = 0; mStart = 0; mEom = 0; mIrq = 0;
    end else begin
      tk      = (mPre == DIV - 1);
      cmdOk   = txCmd && txModeEn;
      needDly = !(brickMode && mWin);
      if (thresholdCfg == 0) dataOk = !fifoEmpty;
      else dataOk = (int'(fifoLevel) > int'(thresholdCfg)) || txComplete;
      go   = mArmed && txModeEn && (mCnt == 0) && !pulseBusy && !mActive && dataOk;
      done = mActive && frameDone;

      if (cmdOk && needDly) begin
        mCnt = int'(delayCfg); mPre = 0;
      end else begin
        if (tk && mCnt > 0) mCnt = mCnt - 1;
        mPre = tk ? 0 : mPre + 1;
      end

      if (!txModeEn) mArmed = 0;
      else if (cmdOk) mArmed = 1;
      else if ((go && !brickMode) || (mWin && !brickMode)) mArmed = 0;

      if (!brickMode || !txModeEn) mWin = 0;
      else if (go) mWin = 1;

      mStart = go;
      if (go) begin mActive = 1; mEom = 0; end
      else if (done) begin mActive = 0; mEom = 1; end
      if (done) mIrq = 1;
      else if (eomAck) mIrq = 0;
    end
  end

  always @(negedge clk) begin
    if (rstN && cmpOn) begin
      chk("R1", startPulse, mStart, "startPulse vs model");
      chk("R7", frameActiveN, !mActive, "frameActiveN vs model");
      chk("R8", eomFlag, mEom, "eomFlag vs model");
      chk("R9", eomIrq, mIrq, "eomIrq vs model");
    end
  end

  task automatic cyc();
    @(negedge clk);
    txCmd = 1'b0; frameDone = 1'b0; eomAck = 1'b0;
  endtask

  task automatic waitStart(input string req, input int exp);
    int n = 0;
    do begin cyc(); n++; end while (!startPulse && n < 300);
    chk(req, n, exp, "cycles to start");
  endtask

  task automatic noStart(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      cyc();
      if (startPulse) seen++;
    end
    chk(req, seen, 0, "unexpected starts");
  endtask

  task automatic finishFrame();
    frameDone = 1'b1;
    cyc();
    chk("R8", frameActiveN, 1, "released after done");
    chk("R8", eomIrq, 1, "irq after done");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", startPulse, 0, "reset start");
    chk("R11", frameActiveN, 1, "reset frameActiveN");
    chk("R11", eomFlag, 0, "reset eomFlag");
    chk("R11", eomIrq, 0, "reset eomIrq");
    rstN = 1'b1; cmpOn = 1'b1;
    cyc();

    // R2: zero threshold, empty FIFO blocks, non-empty starts
    txModeEn = 1; brickMode = 0; thresholdCfg = 0; delayCfg = 0;
    fifoLevel = 0; fifoEmpty = 1; txCmd = 1;
    noStart(8, "R2");
    fifoEmpty = 0;
    waitStart("R2", 1);
    chk("R7", frameActiveN, 0, "active with start");
    cyc();
    chk("R7", startPulse, 0, "pulse one cycle");
    finishFrame();

    // R3: nonzero threshold needs level above it, or TC
    thresholdCfg = 4; fifoLevel = 3; fifoEmpty = 0; txCmd = 1;
    noStart(8, "R3");
    fifoLevel = 4;
    noStart(5, "R3");
    fifoLevel = 5;
    waitStart("R3", 1);
    finishFrame();
    fifoLevel = 2; fifoEmpty = 1; txCmd = 1;
    noStart(6, "R3");
    txComplete = 1;
    waitStart("R3", 1);
    txComplete = 0;
    finishFrame();

    // R1: interaction-pulse generator busy holds the start
    thresholdCfg = 0; fifoEmpty = 0; pulseBusy = 1; txCmd = 1;
    noStart(8, "R1");
    pulseBusy = 0;
    waitStart("R1", 1);
    finishFrame();

    // R4/R5: window mode, delay only before first frame
    brickMode = 1; delayCfg = 3; txCmd = 1;
    waitStart("R4", 3 * DIV + 2);
    finishFrame();
    waitStart("R5", 1);
    delayCfg = 5; txCmd = 1;
    cyc();
    finishFrame();
    waitStart("R5", 1);

    // R10: leaving window mode withdraws the command
    brickMode = 0;
    cyc();
    finishFrame();
    noStart(10, "R10");

    // R6: each command reloads the delay and is consumed
    delayCfg = 2; txCmd = 1;
    waitStart("R6", 2 * DIV + 2);
    finishFrame();
    noStart(10, "R6");
    delayCfg = 0; txCmd = 1;
    waitStart("R6", 2);

    // R9: set wins over simultaneous acknowledge
    frameDone = 1; eomAck = 1;
    cyc();
    chk("R9", eomIrq, 1, "set wins over ack");
    eomAck = 1;
    cyc();
    chk("R9", eomIrq, 0, "ack clears");
    frameDone = 1;
    cyc();
    chk("R8", eomIrq, 0, "done ignored when idle");
    chk("R8", eomFlag, 1, "flag kept when idle");
    txCmd = 1;
    waitStart("R7", 2);
    chk("R7", eomFlag, 0, "flag cleared on start");
    finishFrame();

    // R10 / R1: disabling transmit mode cancels, disabled commands dropped
    fifoEmpty = 1; txCmd = 1;
    noStart(3, "R10");
    txModeEn = 0;
    noStart(2, "R10");
    txModeEn = 1; fifoEmpty = 0;
    noStart(8, "R10");
    txModeEn = 0; txCmd = 1;
    noStart(2, "R1");
    txModeEn = 1;
    noStart(6, "R1");
    txCmd = 1;
    waitStart("R1", 2);
    finishFrame();
    noStart(4, "R6");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule